// File: doc/BRIEF.md
# Synchronous infrared frame transmitter with bit stuffing and CRC-16

This block turns a stream of payload bytes into a complete synchronous infrared frame on one output line. A frame opens with a configurable number of 0x7E flags. The payload follows least significant bit first. After the payload comes a 16-bit frame check sequence and then one closing flag. A zero is inserted after every run of five ones in the payload and check sequence, so that the flag pattern can never appear inside a frame.

Each line bit is then shaped into a pulse. A quarter-bit enable input, `qtick`, sets the rate, and one bit lasts `TICKS_PER_BIT` ticks. A zero bit is sent as a pulse during the first `PULSE_TICKS` ticks of its bit time. A one bit is sent as no pulse. Bytes enter on a valid/ready handshake, and the last byte of a frame is marked with `s_last`. The source must present each following byte within one bit time after `s_ready` rises. Between frames the line carries no pulses.

Top module: `mir_hdlc_tx`

## Requirements
- R1: After reset, `ir_out` is low and `s_ready` is high.
- R2: Each line bit lasts exactly 4 `qtick` ticks. A zero bit drives `ir_out` high for the first tick period of the bit only. A one bit leaves `ir_out` low for the whole bit. `ir_out` changes only after an edge on which `qtick` was high.
- R3: A frame starts with two flags of value 0x7E, each sent least significant bit first (line order 0,1,1,1,1,1,1,0). No zero is inserted into these flags.
- R4: Payload bytes follow the opening flags in the order they were accepted, each least significant bit first.
- R5: In the payload and the check sequence, one zero bit is inserted after every fifth consecutive one bit. This includes a run that ends on the last check-sequence bit, in which case the zero comes before the closing flag.
- R6: The check sequence uses the CRC with polynomial x^16+x^12+x^5+1. The CRC is preset to 0xFFFF, runs over the payload bits in line order, and is sent ones-complemented, low byte first, each byte least significant bit first. For the payload "123456789" the transmitted check bytes are 0x6E then 0x90.
- R7: The check sequence is followed by one 0x7E closing flag. After the closing flag the line stays free of pulses until the next frame's first flag.
- R8: `s_ready` is low from the acceptance of a frame's first byte until that byte's last bit starts on the line. It is also low while the check sequence and closing flag are sent. It returns high only after the closing flag has fully left the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| qtick | input | 1 | Quarter-bit timing enable |
| s_valid | input | 1 | Payload byte valid |
| s_data | input | DATA_W | Payload byte |
| s_last | input | 1 | Marks the final payload byte of a frame |
| s_ready | output | 1 | Block can take a byte this cycle |
| ir_out | output | 1 | Pulse-encoded line output |

## Verification
The bench runs a single-byte frame for every one of the 256 byte values. This sweep separates correct bit order and CRC update from faults that only show on some bit patterns. It also hits runs of ones that end at byte edges and at the end of the check sequence, which is where a misplaced stuff bit would show. A nine-byte ASCII frame fixes the check sequence to a known value, independent of the bench's own CRC model. Multi-byte frames of all-ones and flag-valued payload make stuffing continuous across byte boundaries, and they also expose the handshake timing while the opening flags are sent. Each frame is decoded from the raw pulse slots, so pulse width, bit length and the quiet line after the frame are all checked.

// File: rtl/mir_pkg.sv
package mir_pkg;

   typedef enum logic [2:0] {
      FR_IDLE  = 3'd0,
      FR_OPEN  = 3'd1,
      FR_DATA  = 3'd2,
      FR_FCS   = 3'd3,
      FR_CLOSE = 3'd4
   } fr_state_t;

   localparam int        FLAG_W    = 8;
   localparam logic [7:0] FLAG_PAT = 8'h7E;
   localparam int        RUN_LIMIT = 5;

endpackage

// File: rtl/mir_crc_lfsr.sv
module mir_crc_lfsr #(
   parameter int             CRC_W  = 16,
   parameter logic [CRC_W-1:0] POLY_R = 16'h8408,
   parameter logic [CRC_W-1:0] INIT   = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic             din,
   input  logic             shift,
   output logic             lsb
);

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_upd;
   logic             fb;

   if (CRC_W < 2) begin : g_bad_w
      $error("mir_crc_lfsr: CRC_W must be at least 2");
   end

   assign fb = crc_q[0] ^ din;

   for (genvar i = 0; i < CRC_W; i++) begin : g_tap
      if (i == CRC_W - 1) begin : g_top
         assign crc_upd[i] = fb & POLY_R[i];
      end else begin : g_mid
         assign crc_upd[i] = crc_q[i+1] ^ (fb & POLY_R[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= INIT;
      end else if (clr) begin
         crc_q <= INIT;
      end else if (adv) begin
         crc_q <= crc_upd;
      end else if (shift) begin
         crc_q <= {1'b0, crc_q[CRC_W-1:1]};
      end
   end

   assign lsb = crc_q[0];

endmodule

// File: rtl/mir_pulse_enc.sv
module mir_pulse_enc #(
   parameter int TICKS_PER_BIT = 4,
   parameter int PULSE_TICKS   = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic qtick,
   input  logic nxt_valid,
   input  logic nxt_bit,
   output logic take,
   output logic active,
   output logic ir_out
);

   localparam int PW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
   localparam logic [PW-1:0] PH_LAST  = PW'(TICKS_PER_BIT - 1);
   localparam logic [PW-1:0] PH_PULSE = PW'(PULSE_TICKS);

   if (TICKS_PER_BIT < 2) begin : g_bad_tpb
      $error("mir_pulse_enc: TICKS_PER_BIT must be at least 2");
   end
   if (PULSE_TICKS < 1 || PULSE_TICKS >= TICKS_PER_BIT) begin : g_bad_pt
      $error("mir_pulse_enc: PULSE_TICKS must lie in 1..TICKS_PER_BIT-1");
   end

   logic [PW-1:0] phase;
   logic          cur_bit;
   logic          slot_end;

   assign slot_end = qtick && (!active || phase == PH_LAST);
   assign take     = slot_end && nxt_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= '0;
         cur_bit <= 1'b1;
         active  <= 1'b0;
      end else if (slot_end) begin
         phase <= '0;
         if (nxt_valid) begin
            cur_bit <= nxt_bit;
            active  <= 1'b1;
         end else begin
            cur_bit <= 1'b1;
            active  <= 1'b0;
         end
      end else if (qtick) begin
         phase <= phase + 1'b1;
      end
   end

   assign ir_out = active && !cur_bit && (phase < PH_PULSE);

endmodule

// File: rtl/mir_framer.sv
module mir_framer
   import mir_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int START_FLAGS = 2,
   parameter int CRC_W       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_valid,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_last,
   output logic              s_ready,
   input  logic              enc_active,
   input  logic              take,
   output logic              nxt_valid,
   output logic              nxt_bit,
   output logic              crc_clr,
   output logic              crc_adv,
   output logic              crc_din,
   output logic              crc_shift,
   input  logic              crc_lsb,
   output fr_state_t         st_o,
   output logic [2:0]        ones_o
);

   localparam int OPEN_BITS = START_FLAGS * FLAG_W;
   localparam int MAX_A     = (OPEN_BITS > CRC_W) ? OPEN_BITS : CRC_W;
   localparam int MAX_B     = (MAX_A > DATA_W) ? MAX_A : DATA_W;
   localparam int CW        = $clog2(MAX_B + 1);

   if (START_FLAGS < 1) begin : g_bad_sf
      $error("mir_framer: START_FLAGS must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("mir_framer: DATA_W must be at least 1");
   end

   fr_state_t         state;
   logic [DATA_W-1:0] sh;
   logic              buf_full;
   logic              last_q;
   logic [CW-1:0]     cnt;
   logic [2:0]        ones;
   logic              stuff;
   logic              accept;
   logic              cur_one;

   assign stuff = (ones == 3'(RUN_LIMIT)) &&
                  (state == FR_DATA || state == FR_FCS || state == FR_CLOSE);

   always_comb begin
      nxt_valid = 1'b0;
      nxt_bit   = 1'b1;
      case (state)
         FR_OPEN: begin
            nxt_valid = 1'b1;
            nxt_bit   = FLAG_PAT[cnt[2:0]];
         end
         FR_DATA: begin
            if (stuff) begin
               nxt_valid = 1'b1;
               nxt_bit   = 1'b0;
            end else begin
               nxt_valid = buf_full;
               nxt_bit   = sh[0];
            end
         end
         FR_FCS: begin
            nxt_valid = 1'b1;
            nxt_bit   = stuff ? 1'b0 : ~crc_lsb;
         end
         FR_CLOSE: begin
            nxt_valid = 1'b1;
            nxt_bit   = stuff ? 1'b0 : FLAG_PAT[cnt[2:0]];
         end
         default: begin
            nxt_valid = 1'b0;
            nxt_bit   = 1'b1;
         end
      endcase
   end

   assign s_ready = !buf_full &&
                    ((state == FR_IDLE && !enc_active) ||
                     (state == FR_DATA && !last_q));
   assign accept  = s_valid && s_ready;

   assign cur_one   = nxt_bit;
   assign crc_clr   = accept && (state == FR_IDLE);
   assign crc_adv   = take && (state == FR_DATA) && !stuff;
   assign crc_din   = sh[0];
   assign crc_shift = take && (state == FR_FCS) && !stuff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= FR_IDLE;
         sh       <= '0;
         buf_full <= 1'b0;
         last_q   <= 1'b0;
         cnt      <= '0;
         ones     <= '0;
      end else begin
         if (take) begin
            if (stuff) begin
               ones <= '0;
            end else begin
               case (state)
                  FR_OPEN: begin
                     if (cnt == CW'(OPEN_BITS - 1)) begin
                        cnt   <= '0;
                        ones  <= '0;
                        state <= FR_DATA;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  FR_DATA: begin
                     ones <= cur_one ? ones + 1'b1 : 3'd0;
                     sh   <= sh >> 1;
                     if (cnt == CW'(DATA_W - 1)) begin
                        cnt      <= '0;
                        buf_full <= 1'b0;
                        if (last_q) begin
                           state <= FR_FCS;
                        end
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  FR_FCS: begin
                     ones <= cur_one ? ones + 1'b1 : 3'd0;
                     if (cnt == CW'(CRC_W - 1)) begin
                        cnt   <= '0;
                        state <= FR_CLOSE;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  FR_CLOSE: begin
                     ones <= '0;
                     if (cnt == CW'(FLAG_W - 1)) begin
                        cnt   <= '0;
                        state <= FR_IDLE;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  default: begin
                     cnt <= '0;
                  end
               endcase
            end
         end
         if (accept) begin
            sh       <= s_data;
            buf_full <= 1'b1;
            last_q   <= s_last;
            if (state == FR_IDLE) begin
               state <= FR_OPEN;
               cnt   <= '0;
               ones  <= '0;
            end
         end
      end
   end

   assign st_o   = state;
   assign ones_o = ones;

endmodule

// File: rtl/mir_hdlc_tx.sv
module mir_hdlc_tx
   import mir_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int START_FLAGS   = 2,
   parameter int TICKS_PER_BIT = 4,
   parameter int PULSE_TICKS   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              qtick,
   input  logic              s_valid,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_last,
   output logic              s_ready,
   output logic              ir_out
);

   localparam int CRC_W = 16;

   logic      take;
   logic      enc_active;
   logic      nxt_valid;
   logic      nxt_bit;
   logic      crc_clr;
   logic      crc_adv;
   logic      crc_din;
   logic      crc_shift;
   logic      crc_lsb;
   fr_state_t fr_state;
   logic [2:0] fr_ones;

   mir_framer #(
      .DATA_W     (DATA_W),
      .START_FLAGS(START_FLAGS),
      .CRC_W      (CRC_W)
   ) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_valid   (s_valid),
      .s_data    (s_data),
      .s_last    (s_last),
      .s_ready   (s_ready),
      .enc_active(enc_active),
      .take      (take),
      .nxt_valid (nxt_valid),
      .nxt_bit   (nxt_bit),
      .crc_clr   (crc_clr),
      .crc_adv   (crc_adv),
      .crc_din   (crc_din),
      .crc_shift (crc_shift),
      .crc_lsb   (crc_lsb),
      .st_o      (fr_state),
      .ones_o    (fr_ones)
   );

   mir_crc_lfsr #(
      .CRC_W (CRC_W),
      .POLY_R(16'h8408),
      .INIT  (16'hFFFF)
   ) u_crc (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (crc_clr),
      .adv  (crc_adv),
      .din  (crc_din),
      .shift(crc_shift),
      .lsb  (crc_lsb)
   );

   mir_pulse_enc #(
      .TICKS_PER_BIT(TICKS_PER_BIT),
      .PULSE_TICKS  (PULSE_TICKS)
   ) u_enc (
      .clk      (clk),
      .rst_n    (rst_n),
      .qtick    (qtick),
      .nxt_valid(nxt_valid),
      .nxt_bit  (nxt_bit),
      .take     (take),
      .active   (enc_active),
      .ir_out   (ir_out)
   );

endmodule

// File: rtl/mir_hdlc_tx_chk.sv
module mir_hdlc_tx_chk
   import mir_pkg::*;
#(
   parameter int PULSE_TICKS = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       qtick,
   input logic       ir_out,
   input logic       s_ready,
   input logic       enc_active,
   input fr_state_t  fr_state,
   input logic [2:0] fr_ones
);

   logic [7:0] hi_ticks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_ticks <= '0;
      end else if (!ir_out) begin
         hi_ticks <= '0;
      end else if (qtick && hi_ticks != 8'hFF) begin
         hi_ticks <= hi_ticks + 1'b1;
      end
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         a_reset_quiet_r1: assert (!ir_out);
      end
   end

   p_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !qtick |=> $stable(ir_out));

   p_pulse_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ir_out |-> (hi_ticks < 8'(PULSE_TICKS)));

   p_run_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fr_ones <= 3'(RUN_LIMIT));

   p_dark_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fr_state == FR_IDLE && !enc_active) |-> !ir_out);

   p_busy_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fr_state == FR_OPEN || fr_state == FR_FCS || fr_state == FR_CLOSE) |-> !s_ready);

   p_close_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fr_state == FR_IDLE && enc_active) |-> !s_ready);

endmodule

bind mir_hdlc_tx mir_hdlc_tx_chk #(.PULSE_TICKS(PULSE_TICKS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .qtick     (qtick),
   .ir_out    (ir_out),
   .s_ready   (s_ready),
   .enc_active(enc_active),
   .fr_state  (fr_state),
   .fr_ones   (fr_ones)
);

// File: tb/sim_mir_hdlc_tx.sv
module sim_mir_hdlc_tx;

   localparam int CLK_PERIOD = 10;
   localparam int TDIV       = 2;
   localparam int TPB        = 4;
   localparam int MAXSLOT    = 8192;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       qtick = 1'b0;
   logic       s_valid = 1'b0;
   logic [7:0] s_data = 8'h00;
   logic       s_last = 1'b0;
   logic       s_ready;
   logic       ir_out;

   int checks = 0;
   int errors = 0;

   logic [7:0] pay [0:63];
   int         npay;
   logic       ebits [0:1023];
   int         nexp;
   logic       slots [0:MAXSLOT-1];
   int         nslots;
   logic       rec_on = 1'b0;
   time        acc_t [0:63];
   int         eones;

   mir_hdlc_tx u0 (
      .clk    (clk),
      .rst_n  (rst_n),
      .qtick  (qtick),
      .s_valid(s_valid),
      .s_data (s_data),
      .s_last (s_last),
      .s_ready(s_ready),
      .ir_out (ir_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin : tick_rec
      int tcnt;
      tcnt = 0;
      forever begin
         @(negedge clk);
         if (qtick && rec_on && nslots < MAXSLOT) begin
            if (nslots > 0 || ir_out) begin
               slots[nslots] = ir_out;
               nslots++;
            end
         end
         qtick = (tcnt == TDIV - 1);
         tcnt  = (tcnt + 1) % TDIV;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic push_bit(input logic b);
      ebits[nexp] = b;
      nexp++;
   endtask

   task automatic push_stuffed(input logic b);
      push_bit(b);
      eones = b ? eones + 1 : 0;
      if (eones == 5) begin
         push_bit(1'b0);
         eones = 0;
      end
   endtask

   task automatic build_expected();
      logic [15:0] crc;
      logic [15:0] fcs;
      logic        fb;
      nexp  = 0;
      eones = 0;
      for (int f = 0; f < 2; f++)
         for (int i = 0; i < 8; i++) push_bit(((8'h7E >> i) & 8'h01) != 0);
      crc = 16'hFFFF;
      for (int k = 0; k < npay; k++) begin
         for (int i = 0; i < 8; i++) begin
            fb  = crc[0] ^ pay[k][i];
            crc = crc >> 1;
            if (fb) crc = crc ^ 16'h8408;
            push_stuffed(pay[k][i]);
         end
      end
      fcs = ~crc;
      for (int i = 0; i < 16; i++) push_stuffed(fcs[i]);
      for (int i = 0; i < 8; i++) push_bit(((8'h7E >> i) & 8'h01) != 0);
   endtask

   task automatic send_frame();
      for (int k = 0; k < npay; k++) begin
         s_data  = pay[k];
         s_last  = (k == npay - 1);
         s_valid = 1'b1;
         while (!s_ready) @(negedge clk);
         acc_t[k] = $time;
         @(negedge clk);
      end
      s_valid = 1'b0;
      s_last  = 1'b0;
   endtask

   task automatic run_frame(input string tag);
      bit shape_ok, flag_ok, seq_ok, tail_ok;
      int bad_at;
      build_expected();
      nslots = 0;
      rec_on = 1'b1;
      send_frame();
      repeat (2) @(negedge clk);
      while (!s_ready) @(negedge clk);
      repeat (10 * TPB * TDIV) @(negedge clk);
      rec_on = 1'b0;

      shape_ok = 1;
      for (int s = 0; s < nslots; s++)
         if ((s % TPB) != 0 && slots[s]) shape_ok = 0;
      chk(shape_ok, "R2", {tag, " pulse only in first quarter"}, shape_ok, 1);

      flag_ok = (nslots >= 16 * TPB);
      for (int b = 0; b < 16 && flag_ok; b++)
         if (!slots[b * TPB] != ebits[b]) flag_ok = 0;
      chk(flag_ok, "R3", {tag, " opening flags"}, flag_ok, 1);

      seq_ok = (nslots >= nexp * TPB);
      bad_at = -1;
      for (int b = 16; b < nexp && seq_ok; b++)
         if (!slots[b * TPB] != ebits[b]) begin
            seq_ok = 0;
            bad_at = b;
         end
      chk(seq_ok, "R4 R5 R6", {tag, " payload/stuff/fcs bit stream, first bad bit"}, bad_at, -1);

      tail_ok = (nslots >= nexp * TPB);
      for (int s = nexp * TPB; s < nslots; s++)
         if (slots[s]) tail_ok = 0;
      chk(tail_ok, "R7", {tag, " closing flag then quiet line, slots"}, nslots, nexp * TPB);
      chk(s_ready == 1'b1, "R8", {tag, " ready back after frame"}, s_ready, 1);
   endtask

   task automatic fcs_known_check();
      int          ones_seen;
      logic        dbits [0:1023];
      int          nd;
      logic [15:0] got;
      ones_seen = 0;
      nd = 0;
      for (int b = 16; b < nexp - 8; b++) begin
         logic v;
         v = !slots[b * TPB];
         if (ones_seen == 5) begin
            ones_seen = 0;
         end else begin
            dbits[nd] = v;
            nd++;
            ones_seen = v ? ones_seen + 1 : 0;
         end
      end
      got = '0;
      for (int i = 0; i < 16; i++) got[i] = dbits[nd - 16 + i];
      chk(got == 16'h906E && nd == 9 * 8 + 16, "R6",
          "line fcs for 123456789 (low byte first)", got, 16'h906E);
   endtask

   initial begin : watchdog
      repeat (195000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R7 watchdog actual=hung expected=frames done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      string msg;
      repeat (3) @(negedge clk);
      chk(ir_out == 1'b0, "R1", "ir_out in reset", ir_out, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(ir_out == 1'b0, "R1", "ir_out after reset", ir_out, 0);
      chk(s_ready == 1'b1, "R1", "s_ready after reset", s_ready, 1);

      npay = 9;
      for (int i = 0; i < 9; i++) pay[i] = 8'h31 + 8'(i);
      run_frame("ascii");
      fcs_known_check();
      chk((acc_t[1] - acc_t[0]) >= time'(23 * TPB * TDIV * CLK_PERIOD), "R8",
          "second byte held off during opening flags (ns)", acc_t[1] - acc_t[0],
          23 * TPB * TDIV * CLK_PERIOD);

      npay = 6;
      for (int i = 0; i < 6; i++) pay[i] = 8'hFF;
      run_frame("all-ones");

      npay = 4;
      for (int i = 0; i < 4; i++) pay[i] = 8'h7E;
      run_frame("flag-bytes");

      npay = 3;
      pay[0] = 8'hF8; pay[1] = 8'h1F; pay[2] = 8'h00;
      run_frame("cross-byte-run");

      for (int v = 0; v < 256; v++) begin
         npay   = 1;
         pay[0] = 8'(v);
         msg = $sformatf("byte %02h", v);
         run_frame(msg);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule